// File: doc/BRIEF.md
# Saturating Knob Value Adjuster

This block keeps a 16-bit unsigned setting that a rotary control moves up and down. Each cycle in which `step_valid` is high carries one step request. `dir` chooses the direction: 1 raises the setting and 0 lowers it. `fast` chooses the step size. A slow step moves the setting by one count. A fast step moves it by the current setting divided by eight, rounded down, and by at least one count. Every result is clamped to the range 0 to 65535, so the setting never wraps.

The block has no back-pressure. It takes every step request in the cycle it arrives, and `step_ready` is not needed. The request updates `value` at the next rising clock edge. The step size comes from the setting held in the register before that edge. Decoding the knob's raw signals and measuring how fast it turns are done upstream of this block.

Top module: `knob_value_adj`

## Requirements
- R1: While `rst_n` is low, `value` is 0. Reset is asynchronous and active low.
- R2: In a cycle with `step_valid` low, `value` keeps its level at the next edge, whatever `dir` and `fast` are.
- R3: A slow step (`fast`=0) with `dir`=1 adds one to `value` at the next edge. A slow step with `dir`=0 subtracts one. Both apply only when the result stays in range.
- R4: A slow step that raises 65535 leaves the value at 65535. A slow step that lowers 0 leaves it at 0.
- R5: A fast step uses a step size equal to the pre-edge `value` shifted right by three. When that shift gives zero (values 0 to 7), the step size is 1.
- R6: If a fast raise would go past 65535, `value` becomes 65535.
- R7: If a fast lower would go below 0, `value` becomes 0.
- R8: Each cycle with `step_valid` high applies exactly one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | One step request in this cycle |
| dir | input | 1 | 1 raises the value, 0 lowers it |
| fast | input | 1 | 1 selects the scaled step, 0 the unit step |
| value | output | 16 | Current setting |

## Verification
The bench pushes the top and bottom limits with both step kinds. A design that wraps would jump from 65535 to a small number, or from 0 to a large one. It runs fast steps at values 0 through 9, where the shift gives 0 or 1. A design without the one-count floor would stop moving at values below 8, and a design that took the size from the updated value would be off by one near 8. Random sequences with idle cycles mixed in expose updates applied twice or lost, and idle cycles in which `dir` or `fast` leak through to the value.

// File: rtl/knob_adj_pkg.sv
`timescale 1ns/1ps
package knob_adj_pkg;
  localparam int unsigned KNOB_W     = 16;
  localparam int unsigned KNOB_SHIFT = 3;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_kind_e;
endpackage

// File: rtl/knob_step_size.sv
`timescale 1ns/1ps
module knob_step_size #(
  parameter int unsigned W  = 16,
  parameter int unsigned SH = 3
) (
  input  logic [W-1:0] cur,
  input  logic         fast,
  output logic [W-1:0] amount
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] scaled;

  generate
    if (SH >= W) begin : g_all_shifted_out
      assign scaled = '0;
    end else begin : g_shift
      assign scaled = cur >> SH;
    end
  endgenerate

  always_comb begin
    amount = ONE;
    if (fast && (scaled != '0)) amount = scaled;
  end
endmodule

// File: rtl/knob_sat_addsub.sv
`timescale 1ns/1ps
module knob_sat_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] delta,
  input  logic         up,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] TOP = '1;

  logic [W:0] wide;

  always_comb begin
    if (up) begin
      wide   = {1'b0, base} + {1'b0, delta};
      result = wide[W] ? TOP : wide[W-1:0];
    end else begin
      wide   = {1'b0, base} - {1'b0, delta};
      result = wide[W] ? '0 : wide[W-1:0];
    end
  end
endmodule

// File: rtl/knob_value_adj.sv
`timescale 1ns/1ps
module knob_value_adj #(
  parameter int unsigned W  = knob_adj_pkg::KNOB_W,
  parameter int unsigned SH = knob_adj_pkg::KNOB_SHIFT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_valid,
  input  logic         dir,
  input  logic         fast,
  output logic [W-1:0] value
);
  import knob_adj_pkg::*;

  step_kind_e   kind;
  logic [W-1:0] amount;
  logic [W-1:0] moved;
  logic [W-1:0] next_value;

  always_comb begin
    if (!step_valid) kind = STEP_NONE;
    else if (dir)    kind = STEP_UP;
    else             kind = STEP_DOWN;
  end

  knob_step_size #(.W(W), .SH(SH)) u_size (
    .cur    (value),
    .fast   (fast),
    .amount (amount)
  );

  knob_sat_addsub #(.W(W)) u_sat (
    .base   (value),
    .delta  (amount),
    .up     (kind == STEP_UP),
    .result (moved)
  );

  always_comb begin
    case (kind)
      STEP_UP, STEP_DOWN: next_value = moved;
      default:            next_value = value;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end
endmodule

// File: rtl/knob_value_adj_chk.sv
`timescale 1ns/1ps
module knob_value_adj_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned SH = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_valid,
  input logic         dir,
  input logic         fast,
  input logic [W-1:0] value
);
  localparam logic [W-1:0] TOP   = '1;
  localparam logic [W-1:0] SMALL = W'(8);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> $stable(value));

  // R3
  slow_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !fast && dir && value != TOP |=> value == W'($past(value) + 1'b1));

  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && dir && value == TOP |=> value == TOP);

  // R4
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !dir && value == '0 |=> value == '0);

  // R5
  fast_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && fast && dir && value < SMALL |=> value == W'($past(value) + 1'b1));

  // R6
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && dir |=> value >= $past(value));

  // R7
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !dir |=> value <= $past(value));
endmodule

bind knob_value_adj knob_value_adj_chk #(.W(W), .SH(SH)) u_chk (.*);

// File: tb/knob_value_adj_tb.sv
`timescale 1ns/1ps
module knob_value_adj_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic        dir = 1'b0;
  logic        fast = 1'b0;
  logic [15:0] value;

  int checks = 0;
  int errors = 0;
  int mdl = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  knob_value_adj u_dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
    .dir(dir), .fast(fast), .value(value)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: value=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: one request per cycle, expected result pushed to the scoreboard
  task automatic drive(input bit v, input bit d, input bit f);
    int sz, nxt;
    string tag;
    @(negedge clk);
    step_valid = v; dir = d; fast = f;
    sz = f ? (((mdl >> 3) == 0) ? 1 : (mdl >> 3)) : 1;
    if (!v) begin
      nxt = mdl; tag = "R2";
    end else if (d) begin
      nxt = (mdl + sz > 65535) ? 65535 : mdl + sz;
      tag = (mdl + sz > 65535) ? (f ? "R6" : "R4") : (f ? "R5" : "R3");
    end else begin
      nxt = (mdl - sz < 0) ? 0 : mdl - sz;
      tag = (mdl - sz < 0) ? (f ? "R7" : "R4") : (f ? "R5" : "R3");
    end
    exp_q.push_back(16'(nxt));
    tag_q.push_back(tag);
    mdl = nxt;
  endtask

  task automatic drain();
    @(negedge clk);
    step_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compares each result just after the edge that produced it (R8)
  always @(posedge clk) begin
    if (rst_n && exp_q.size() != 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #1;
      check({t, "/R8"}, int'(value), int'(e));
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: value=%0d expected=done", value);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(value), 0);
    rst_n = 1'b1;

    // idle cycles with noisy dir/fast
    drive(0, 1, 1); drive(0, 0, 0); drive(0, 1, 0);
    // slow down at zero, slow ups
    drive(1, 0, 0); drive(1, 0, 1);
    for (int i = 0; i < 10; i++) drive(1, 1, 1);   // fast at 0..9
    for (int i = 0; i < 5; i++) drive(1, 1, 0);
    for (int i = 0; i < 12; i++) drive(1, 0, 1);   // fast down through small values
    drain();

    // run into the top limit
    for (int i = 0; i < 200; i++) drive(1, 1, 1);
    drive(1, 1, 0); drive(1, 1, 1); drive(0, 0, 1);
    drain();
    check("R6", int'(value), 65535);

    // run into the bottom limit
    for (int i = 0; i < 200; i++) drive(1, 0, 1);
    drive(1, 0, 0); drive(1, 0, 1);
    drain();
    check("R7", int'(value), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      drive(r != 0, $urandom_range(0, 1) == 1, r > 5);
    end
    drain();

    // reset in the middle of operation
    for (int i = 0; i < 20; i++) drive(1, 1, 1);
    drain();
    rst_n = 1'b0;
    #1;
    check("R1", int'(value), 0);
    mdl = 0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, 0);
    drain();
    check("R3", int'(value), 1);

    report();
  end
endmodule